// File: doc/BRIEF.md
# Connection Memory Block-Fill Engine

This block loads one fixed word into every location of two connection memories, a local one and a backplane one, with a single register command. Software first raises a master arming bit. It then writes the fill register with its start bit set and a 3-bit pattern for each memory. The engine sweeps the whole address range of both memories together, one address per clock. Each word carries the memory's pattern in its three top bits and zeros in every bit below. When the sweep ends, the start bit clears itself, and software polls it as the completion flag.

A fill can be cut short at any time, either by writing the start bit low or by dropping the master bit. Locations already written keep their new contents. The next start begins again at address 0. The engine owns the write port of each memory. When no fill is running, ordinary processor writes pass through it to the port. While a fill runs, processor writes are refused and a stall flag is raised.

Top module: `cmf_fill`

## Requirements
- R1: After reset the start bit reads 0, neither memory write strobe is asserted and the stall flag is low.
- R2: A start write (fill register write with start bit 1) begins a fill only when the master bit has gone from 0 to 1 at least one clock earlier and is still 1. A master bit held high through reset does not count as a rise. A start write without such a rise leaves the start bit at 0 and produces no writes.
- R3: A fill writes addresses 0 to DEPTH-1 in ascending order, one per clock, to both memories in the same cycle at the same address. The first write is presented the cycle after the start bit first reads 1.
- R4: Every local fill word is the local pattern in bits 15:13 with bits 12:0 zero.
- R5: Every backplane fill word is the backplane pattern in bits 15:13 with bits 12:0 zero.
- R6: The start bit reads 0 exactly DEPTH cycles after it first reads 1, and exactly DEPTH fill writes occur, with none afterwards. At 125 MHz this is about 65.5 µs for 8,192 words, inside the 125 µs limit.
- R7: A fill register write with start bit 0 during a fill stops it at that clock edge. No write strobe follows, and the start bit reads 0.
- R8: The master bit sampled low during a fill stops it at that clock edge, in the same way as R7.
- R9: A fill started after an aborted fill begins again at address 0.
- R10: A start write that arrives while a fill is running is ignored. The fill does not restart, its length stays DEPTH cycles, and its words keep the patterns captured at the original start.
- R11: A processor write made when no fill is running appears on the selected memory's port one cycle later, with the same address and data. Select value 0 picks the local memory and 1 picks the backplane memory. The other port stays idle.
- R12: While a fill is running the stall flag is high and processor writes are dropped. No processor word reaches either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_master | input | 1 | Master arming bit from the control register |
| fill_wr | input | 1 | Write strobe for the fill register |
| fill_wr_go | input | 1 | Start bit value carried by the write |
| fill_wr_lpat | input | 3 | Local pattern carried by the write |
| fill_wr_bpat | input | 3 | Backplane pattern carried by the write |
| fill_go | output | 1 | Start bit readback, high while a fill runs |
| cpu_wr | input | 1 | Processor write request |
| cpu_sel | input | 1 | Target memory: 0 local, 1 backplane |
| cpu_addr | input | 13 | Processor write address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_stall | output | 1 | High while processor writes are refused |
| loc_we | output | 1 | Local memory write strobe |
| loc_addr | output | 13 | Local memory write address |
| loc_wdata | output | 16 | Local memory write data |
| bp_we | output | 1 | Backplane memory write strobe |
| bp_addr | output | 13 | Backplane memory write address |
| bp_wdata | output | 16 | Backplane memory write data |

## Verification
The assertions check on every cycle the properties that are local in time:
- both ports move in lockstep with an address step of one;
- fill words have clear low bits;
- either abort path drops the start bit at the next edge;
- a rising start bit always follows a qualified start write.

Only the bench scenarios can show the properties that span a whole sweep or depend on a particular history. These are the exact fill length and write count, the pattern values in the top bits, the restart from address 0 after an abort, the ignored second start, and the refusal to arm when the master bit was already high out of reset.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

  // Default geometry of each connection memory
  localparam int unsigned CM_DEPTH  = 8192;
  localparam int unsigned CM_DATA_W = 16;
  localparam int unsigned CM_PAT_W  = 3;

  // Number of memories served and their select codes
  localparam int unsigned CM_NUM       = 2;
  localparam int unsigned CM_SEL_LOCAL = 0;
  localparam int unsigned CM_SEL_BACK  = 1;

endpackage

// File: rtl/cmf_ctrl.sv
// Arming, start, abort and completion control for the fill sweep.
module cmf_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic reg_wr,
  input  logic reg_go,
  input  logic last,
  output logic active,
  output logic start,
  output logic step
);

  logic master_q;
  logic armed;
  logic abort;

  assign start = reg_wr && reg_go && master && armed && !active;
  assign abort = active && (!master || (reg_wr && !reg_go));
  assign step  = active && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b1;   // a level already high out of reset is no rise
      armed    <= 1'b0;
      active   <= 1'b0;
    end else begin
      master_q <= master;
      if (!master)
        armed <= 1'b0;
      else if (!master_q)
        armed <= 1'b1;
      if (start)
        active <= 1'b1;
      else if (abort || (step && last))
        active <= 1'b0;
    end
  end

endmodule

// File: rtl/cmf_addr_ctr.sv
// Sweep address counter: cleared on start, advanced per fill write.
module cmf_addr_ctr #(
  parameter int unsigned DEPTH = 8192,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] cnt,
  output logic          last
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  assign last = (cnt == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (inc)
      cnt <= cnt + AW'(1);
  end

endmodule

// File: rtl/cmf_wport.sv
// Registered write port of one memory: fill traffic wins over processor.
module cmf_wport #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_go,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          cpu_go,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      we   <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      we <= fill_go || cpu_go;
      if (fill_go) begin
        addr <= fill_addr;
        data <= fill_data;
      end else if (cpu_go) begin
        addr <= cpu_addr;
        data <= cpu_data;
      end
    end
  end

endmodule

// File: rtl/cmf_fill.sv
module cmf_fill
  import cmf_pkg::*;
#(
  parameter int unsigned DEPTH = CM_DEPTH,
  parameter int unsigned DW    = CM_DATA_W,
  parameter int unsigned PW    = CM_PAT_W,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_master,
  input  logic          fill_wr,
  input  logic          fill_wr_go,
  input  logic [PW-1:0] fill_wr_lpat,
  input  logic [PW-1:0] fill_wr_bpat,
  output logic          fill_go,
  input  logic          cpu_wr,
  input  logic          cpu_sel,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          loc_we,
  output logic [AW-1:0] loc_addr,
  output logic [DW-1:0] loc_wdata,
  output logic          bp_we,
  output logic [AW-1:0] bp_addr,
  output logic [DW-1:0] bp_wdata
);

  localparam int unsigned LOW_W = DW - PW;

  logic          active;
  logic          start;
  logic          step;
  logic          last;
  logic [AW-1:0] sweep_addr;

  logic [CM_NUM-1:0][PW-1:0] pat_q;
  logic [CM_NUM-1:0][PW-1:0] pat_in;
  logic [CM_NUM-1:0]         we_v;
  logic [CM_NUM-1:0][AW-1:0] addr_v;
  logic [CM_NUM-1:0][DW-1:0] data_v;

  cmf_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .master (ctl_master),
    .reg_wr (fill_wr),
    .reg_go (fill_wr_go),
    .last   (last),
    .active (active),
    .start  (start),
    .step   (step)
  );

  cmf_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .inc  (step),
    .cnt  (sweep_addr),
    .last (last)
  );

  assign pat_in[CM_SEL_LOCAL] = fill_wr_lpat;
  assign pat_in[CM_SEL_BACK]  = fill_wr_bpat;

  // Patterns are captured only by the write that starts a fill
  always_ff @(posedge clk) begin
    if (rst)
      pat_q <= '0;
    else if (start)
      pat_q <= pat_in;
  end

  for (genvar g = 0; g < CM_NUM; g++) begin : g_port
    logic          cpu_go_g;
    logic [DW-1:0] word_g;

    assign cpu_go_g = cpu_wr && !active && (cpu_sel == 1'(g));
    assign word_g   = {pat_q[g], {LOW_W{1'b0}}};

    cmf_wport #(.AW(AW), .DW(DW)) u_wport (
      .clk       (clk),
      .rst       (rst),
      .fill_go   (step),
      .fill_addr (sweep_addr),
      .fill_data (word_g),
      .cpu_go    (cpu_go_g),
      .cpu_addr  (cpu_addr),
      .cpu_data  (cpu_wdata),
      .we        (we_v[g]),
      .addr      (addr_v[g]),
      .data      (data_v[g])
    );
  end

  assign fill_go   = active;
  assign cpu_stall = active;

  assign loc_we    = we_v[CM_SEL_LOCAL];
  assign loc_addr  = addr_v[CM_SEL_LOCAL];
  assign loc_wdata = data_v[CM_SEL_LOCAL];
  assign bp_we     = we_v[CM_SEL_BACK];
  assign bp_addr   = addr_v[CM_SEL_BACK];
  assign bp_wdata  = data_v[CM_SEL_BACK];

endmodule

// File: rtl/cmf_fill_chk.sv
module cmf_fill_chk #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_master,
  input logic          fill_wr,
  input logic          fill_wr_go,
  input logic          fill_go,
  input logic          cpu_stall,
  input logic          loc_we,
  input logic [AW-1:0] loc_addr,
  input logic [DW-1:0] loc_wdata,
  input logic          bp_we,
  input logic [AW-1:0] bp_addr,
  input logic [DW-1:0] bp_wdata
);

  localparam int unsigned LOW_W = DW - PW;

  assert_lockstep_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && $past(cpu_stall)) |-> (loc_we && bp_we && loc_addr == bp_addr));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && $past(cpu_stall) && loc_we && $past(loc_we))
      |-> (loc_addr == $past(loc_addr) + AW'(1)));

  assert_loc_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_stall) && loc_we) |-> (loc_wdata[LOW_W-1:0] == '0));

  assert_bp_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_stall) && bp_we) |-> (bp_wdata[LOW_W-1:0] == '0));

  assert_abort_reg_R7: assert property (@(posedge clk) disable iff (rst)
    (fill_wr && !fill_wr_go && cpu_stall) |=> (!fill_go && !loc_we && !bp_we));

  assert_abort_master_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl_master |=> !fill_go);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_go) |-> $past(fill_wr && fill_wr_go && ctl_master));

endmodule

bind cmf_fill cmf_fill_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_master (ctl_master),
  .fill_wr    (fill_wr),
  .fill_wr_go (fill_wr_go),
  .fill_go    (fill_go),
  .cpu_stall  (cpu_stall),
  .loc_we     (loc_we),
  .loc_addr   (loc_addr),
  .loc_wdata  (loc_wdata),
  .bp_we      (bp_we),
  .bp_addr    (bp_addr),
  .bp_wdata   (bp_wdata)
);

// File: tb/cmf_fill_bench.sv
`timescale 1ns/1ps
module cmf_fill_bench;

  localparam int DEPTH = 8192;
  localparam int AW    = 13;
  localparam int DW    = 16;

  // {lpat, bpat, expected local word, expected backplane word}
  localparam logic [37:0] VEC [0:3] = '{
    {3'd0, 3'd0, 16'h0000, 16'h0000},
    {3'd7, 3'd5, 16'hE000, 16'hA000},
    {3'd1, 3'd2, 16'h2000, 16'h4000},
    {3'd4, 3'd3, 16'h8000, 16'h6000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_master = 1'b1;
  logic          fill_wr = 1'b0;
  logic          fill_wr_go = 1'b0;
  logic [2:0]    fill_wr_lpat = '0;
  logic [2:0]    fill_wr_bpat = '0;
  logic          fill_go;
  logic          cpu_wr = 1'b0;
  logic          cpu_sel = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_stall;
  logic          loc_we;
  logic [AW-1:0] loc_addr;
  logic [DW-1:0] loc_wdata;
  logic          bp_we;
  logic [AW-1:0] bp_addr;
  logic [DW-1:0] bp_wdata;

  int n_vec = 0;
  int n_bad = 0;

  // write monitor state
  logic          mon_on = 1'b0;
  logic [AW-1:0] exp_next = '0;
  logic [DW-1:0] exp_l = '0;
  logic [DW-1:0] exp_b = '0;
  int wr_cnt = 0, addr_err = 0, ldat_err = 0, bdat_err = 0;
  int tick = 0, t0 = 0;

  always #4 clk = ~clk;   // 125 MHz

  cmf_fill u_cmf_fill (
    .clk(clk), .rst(rst), .ctl_master(ctl_master),
    .fill_wr(fill_wr), .fill_wr_go(fill_wr_go),
    .fill_wr_lpat(fill_wr_lpat), .fill_wr_bpat(fill_wr_bpat),
    .fill_go(fill_go), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata)
  );

  always @(posedge clk) tick <= tick + 1;

  always @(negedge clk) begin
    if (mon_on && (loc_we || bp_we)) begin
      if (!(loc_we && bp_we) || loc_addr != exp_next || bp_addr != exp_next)
        addr_err++;
      if (loc_wdata != exp_l) ldat_err++;
      if (bp_wdata != exp_b) bdat_err++;
      exp_next = exp_next + AW'(1);
      wr_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic reg_write(input logic go, input logic [2:0] lp, input logic [2:0] bp);
    fill_wr = 1'b1; fill_wr_go = go; fill_wr_lpat = lp; fill_wr_bpat = bp;
    @(negedge clk);
    fill_wr = 1'b0; fill_wr_go = 1'b0;
  endtask

  task automatic start_fill(input logic [2:0] lp, input logic [2:0] bp,
                            input logic [DW-1:0] le, input logic [DW-1:0] be);
    exp_l = le; exp_b = be; exp_next = '0;
    wr_cnt = 0; addr_err = 0; ldat_err = 0; bdat_err = 0;
    mon_on = 1'b1;
    reg_write(1'b1, lp, bp);
    t0 = tick;
  endtask

  task automatic finish_fill(input string tag);
    int guard = 0;
    while (fill_go && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check({"R6 fill length ", tag}, tick - t0, DEPTH);
    @(negedge clk);
    @(negedge clk);
    check({"R6 write count ", tag}, wr_cnt, DEPTH);
    check({"R3 address order ", tag}, addr_err, 0);
    check({"R4 local words ", tag}, ldat_err, 0);
    check({"R5 backplane words ", tag}, bdat_err, 0);
    mon_on = 1'b0;
  endtask

  initial begin
    #(8ns * 190000);
    n_bad++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 start bit", fill_go, 0);
    check("R1 write strobes", {loc_we, bp_we}, 0);
    check("R1 stall", cpu_stall, 0);

    // R2 master high since reset is no rise: start ignored
    mon_on = 1'b1; wr_cnt = 0;
    reg_write(1'b1, 3'd7, 3'd7);
    repeat (4) @(negedge clk);
    check("R2 no rise start bit", fill_go, 0);
    check("R2 no rise writes", wr_cnt, 0);
    mon_on = 1'b0;

    // arm: low then high
    ctl_master = 1'b0; repeat (2) @(negedge clk);
    ctl_master = 1'b1; repeat (2) @(negedge clk);

    // vector table: full fills with each pattern pair
    for (int i = 0; i < 4; i++) begin
      start_fill(VEC[i][37:35], VEC[i][34:32], VEC[i][31:16], VEC[i][15:0]);
      check("R3 start bit after start", fill_go, 1);
      finish_fill($sformatf("vec%0d", i));
    end

    // R7 abort by register write after 99 writes
    start_fill(3'd2, 3'd6, 16'h4000, 16'hC000);
    repeat (99) @(negedge clk);
    reg_write(1'b0, 3'd2, 3'd6);
    check("R7 start bit after abort", fill_go, 0);
    repeat (3) @(negedge clk);
    check("R7 writes before abort", wr_cnt, 99);
    check("R7 stall after abort", cpu_stall, 0);
    mon_on = 1'b0;

    // R9 restart begins at address 0 and runs full length
    start_fill(3'd5, 3'd1, 16'hA000, 16'h2000);
    finish_fill("R9 restart");

    // R8 abort by master low after 36 writes
    start_fill(3'd6, 3'd6, 16'hC000, 16'hC000);
    repeat (36) @(negedge clk);
    ctl_master = 1'b0;
    @(negedge clk);
    check("R8 start bit after master low", fill_go, 0);
    repeat (3) @(negedge clk);
    check("R8 writes before abort", wr_cnt, 36);
    mon_on = 1'b0;

    // R2 master still low: start ignored
    mon_on = 1'b1; wr_cnt = 0;
    reg_write(1'b1, 3'd1, 3'd1);
    repeat (3) @(negedge clk);
    check("R2 master low start bit", fill_go, 0);
    check("R2 master low writes", wr_cnt, 0);
    mon_on = 1'b0;
    ctl_master = 1'b1; repeat (2) @(negedge clk);

    // R11 processor write while idle, backplane select
    cpu_wr = 1'b1; cpu_sel = 1'b1; cpu_addr = 13'h0123; cpu_wdata = 16'hBEEF;
    @(negedge clk);
    cpu_wr = 1'b0;
    check("R11 bp strobe", bp_we, 1);
    check("R11 bp addr", bp_addr, 13'h0123);
    check("R11 bp data", bp_wdata, 16'hBEEF);
    check("R11 local idle", loc_we, 0);
    @(negedge clk);
    check("R11 single write", bp_we, 0);

    // R11 local select
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_addr = 13'h1FFE; cpu_wdata = 16'h0A5A;
    @(negedge clk);
    cpu_wr = 1'b0;
    check("R11 local strobe", loc_we, 1);
    check("R11 local addr", loc_addr, 13'h1FFE);
    check("R11 local data", loc_wdata, 16'h0A5A);
    check("R11 bp idle", bp_we, 0);
    @(negedge clk);

    // R10 and R12: second start and processor write mid-fill are ignored
    start_fill(3'd3, 3'd4, 16'h6000, 16'h8000);
    repeat (50) @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_addr = 13'h0005; cpu_wdata = 16'h1234;
    check("R12 stall during fill", cpu_stall, 1);
    reg_write(1'b1, 3'd7, 3'd7);
    cpu_wr = 1'b0;
    check("R10 still running", fill_go, 1);
    finish_fill("R10 R12 mid-fill");

    summary();
  end

endmodule